// File: doc/BRIEF.md
# PHY register access bridge

This block gives host software a single 32-bit control/status word through which it can read and write the registers of an attached physical-layer device. The host writes a command (read, write or both) together with a 4-bit PHY register address and an 8-bit data byte. The bridge then places one request at a time on a valid/ready request channel toward the PHY. Each command bit drops by itself once its request has been taken.

Register data that the PHY sends back arrives on a one-cycle response strobe. The bridge keeps the returned address and data in the low half of the word and raises a sticky receive interrupt, which the host clears with a write-one-to-clear strobe. A diagnostic enable input lets the host also write the returned fields, so that response handling can be tested without a PHY.

Bit numbering in the requirements below is the Verilog one: bit 31 is the most significant bit of `host_wdata` and `host_rdata`.

Behaviour of the request sequencer:
- The sequencer has three states: `ST_IDLE`, `ST_SEND_RD` and `ST_SEND_WR`.
- It moves from `ST_IDLE` to `ST_SEND_RD` when a read command is pending, whether or not a write command is also pending.
- It moves from `ST_IDLE` to `ST_SEND_WR` when only a write command is pending.
- From either send state it returns to `ST_IDLE` on the clock edge at which `req_valid && req_ready` holds.

Top module: `phy_reg_bridge`

## Requirements
- R1: While `rst_n` is low and after reset, `host_rdata` is 0, `rx_irq` is 0 and `req_valid` is 0.
- R2: A host write loads the request address from bits 27:24 and the request data from bits 23:16; both read back in the same positions one edge later. Bits 29:28 and 15:12 always read as 0.
- R3: Writing 1 to bit 31 (read command) sets that bit. Two edges after the write, `req_valid` is 1 with `req_is_write`=0 and `req_addr` equal to the stored address.
- R4: Writing 1 to bit 30 (write command) sets that bit. Two edges after the write, `req_valid` is 1 with `req_is_write`=1, and `req_addr`/`req_data` equal to the stored address and data.
- R5: While `req_valid` is 1 and `req_ready` is 0, the request and its payload stay unchanged and the command bit stays set. The command bit reads 0 one edge after the handshake edge, unless the host sets it again in that same cycle.
- R6: When both command bits are set, the read request is issued first. The write request follows only after the read has been accepted, so at most one request is outstanding.
- R7: A `rsp_valid` pulse loads `rsp_addr` into bits 11:8 and `rsp_data` into bits 7:0, and sets `rx_irq`, one edge later.
- R8: `rx_irq` stays set until an `irq_clr` pulse clears it. When `rsp_valid` and `irq_clr` are high in the same cycle, `rx_irq` stays set.
- R9: A host write to bits 11:0 takes effect only while `diag_wr_en` is 1; otherwise it leaves them unchanged. A diagnostic write does not set `rx_irq`, and a `rsp_valid` in the same cycle takes priority over it.
- R10: Writing 0 to a command bit does not cancel a command that is already pending, and does not alter the payload of a request already on the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe for the control word |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Current control/status word |
| irq_clr | input | 1 | Write-one-to-clear strobe for the receive interrupt |
| diag_wr_en | input | 1 | Diagnostic enable for host writes to the returned fields |
| req_valid | output | 1 | Request to the PHY is valid |
| req_ready | input | 1 | PHY accepts the request |
| req_is_write | output | 1 | 1 = register write, 0 = register read |
| req_addr | output | 4 | Target PHY register address |
| req_data | output | 8 | Data for a register write |
| rsp_valid | input | 1 | PHY returns register information this cycle |
| rsp_addr | input | 4 | Returned register address |
| rsp_data | input | 8 | Returned register data |
| rx_irq | output | 1 | Sticky receive interrupt |

## Verification
Field loads, response capture and interrupt changes show up one rising edge after their inputs. A newly written command raises `req_valid` two edges after the host write: one edge to store the command bit and one for the sequencer to leave idle. A command bit reads clear one edge after its handshake edge. The bench drives every input after a falling edge and samples every output at the next falling edge, so each check falls in the half-cycle after the edge that is due to produce its value. The random phase compares the word against a bench model every cycle.

// File: rtl/phy_bridge_pkg.sv
package phy_bridge_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned PA_W   = 4;
    localparam int unsigned PD_W   = 8;

    // Field positions inside the control/status word (bit 31 = MSB)
    localparam int unsigned RD_CMD_BIT  = 31;
    localparam int unsigned WR_CMD_BIT  = 30;
    localparam int unsigned TX_ADDR_LSB = 24;
    localparam int unsigned TX_DATA_LSB = 16;
    localparam int unsigned RX_ADDR_LSB = 8;
    localparam int unsigned RX_DATA_LSB = 0;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SEND_RD = 2'd1,
        ST_SEND_WR = 2'd2
    } req_state_e;

    typedef struct packed {
        logic            is_write;
        logic [PA_W-1:0] addr;
        logic [PD_W-1:0] data;
    } phy_req_t;

endpackage

// File: rtl/phy_cmd_regs.sv
module phy_cmd_regs
    import phy_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              rd_done,
    input  logic              wr_done,
    output logic              rd_pend,
    output logic              wr_pend,
    output logic [PA_W-1:0]   tx_addr,
    output logic [PD_W-1:0]   tx_data
);

    logic set_rd;
    logic set_wr;

    always_comb begin
        set_rd = host_wr_en && host_wdata[RD_CMD_BIT];
        set_wr = host_wr_en && host_wdata[WR_CMD_BIT];
    end

    // A host set in the same cycle as a handshake keeps the command pending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
            wr_pend <= 1'b0;
        end else begin
            if (set_rd)       rd_pend <= 1'b1;
            else if (rd_done) rd_pend <= 1'b0;
            if (set_wr)       wr_pend <= 1'b1;
            else if (wr_done) wr_pend <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_addr <= '0;
            tx_data <= '0;
        end else if (host_wr_en) begin
            tx_addr <= host_wdata[TX_ADDR_LSB +: PA_W];
            tx_data <= host_wdata[TX_DATA_LSB +: PD_W];
        end
    end

endmodule

// File: rtl/phy_req_fsm.sv
module phy_req_fsm
    import phy_bridge_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_pend,
    input  logic            wr_pend,
    input  logic [PA_W-1:0] tx_addr,
    input  logic [PD_W-1:0] tx_data,
    input  logic            req_ready,
    output logic            req_valid,
    output phy_req_t        req_out,
    output logic            rd_done,
    output logic            wr_done
);

    req_state_e state_q;
    req_state_e state_d;
    phy_req_t   payload_q;
    logic       accept;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_pend)      state_d = ST_SEND_RD;
                else if (wr_pend) state_d = ST_SEND_WR;
            end
            ST_SEND_RD: if (req_ready) state_d = ST_IDLE;
            ST_SEND_WR: if (req_ready) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register and request payload capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            payload_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && (rd_pend || wr_pend)) begin
                payload_q.is_write <= !rd_pend;
                payload_q.addr     <= tx_addr;
                payload_q.data     <= tx_data;
            end
        end
    end

    // Outputs
    always_comb begin
        req_valid = 1'b0;
        rd_done   = 1'b0;
        wr_done   = 1'b0;
        unique case (state_q)
            ST_IDLE:    req_valid = 1'b0;
            ST_SEND_RD: begin
                req_valid = 1'b1;
                rd_done   = req_ready;
            end
            ST_SEND_WR: begin
                req_valid = 1'b1;
                wr_done   = req_ready;
            end
            default:    req_valid = 1'b0;
        endcase
        accept  = req_valid && req_ready;
        req_out = payload_q;
    end

endmodule

// File: rtl/phy_rsp_regs.sv
module phy_rsp_regs
    import phy_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic              diag_wr_en,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              rsp_valid,
    input  logic [PA_W-1:0]   rsp_addr,
    input  logic [PD_W-1:0]   rsp_data,
    input  logic              irq_clr,
    output logic [PA_W-1:0]   rx_addr,
    output logic [PD_W-1:0]   rx_data,
    output logic              rx_irq
);

    logic diag_load;

    always_comb diag_load = host_wr_en && diag_wr_en;

    // A PHY response beats a diagnostic host write in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_addr <= '0;
            rx_data <= '0;
        end else if (rsp_valid) begin
            rx_addr <= rsp_addr;
            rx_data <= rsp_data;
        end else if (diag_load) begin
            rx_addr <= host_wdata[RX_ADDR_LSB +: PA_W];
            rx_data <= host_wdata[RX_DATA_LSB +: PD_W];
        end
    end

    // Sticky flag: setting wins over clearing
    always_ff @(posedge clk) begin
        if (!rst_n)         rx_irq <= 1'b0;
        else if (rsp_valid) rx_irq <= 1'b1;
        else if (irq_clr)   rx_irq <= 1'b0;
    end

endmodule

// File: rtl/phy_reg_bridge.sv
module phy_reg_bridge
    import phy_bridge_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr_en,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    input  logic        irq_clr,
    input  logic        diag_wr_en,
    output logic        req_valid,
    input  logic        req_ready,
    output logic        req_is_write,
    output logic [3:0]  req_addr,
    output logic [7:0]  req_data,
    input  logic        rsp_valid,
    input  logic [3:0]  rsp_addr,
    input  logic [7:0]  rsp_data,
    output logic        rx_irq
);

    logic            rd_pend;
    logic            wr_pend;
    logic            rd_done;
    logic            wr_done;
    logic [PA_W-1:0] tx_addr;
    logic [PD_W-1:0] tx_data;
    logic [PA_W-1:0] rx_addr;
    logic [PD_W-1:0] rx_data;
    phy_req_t        req_bus;

    phy_cmd_regs u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr_en (host_wr_en),
        .host_wdata (host_wdata),
        .rd_done    (rd_done),
        .wr_done    (wr_done),
        .rd_pend    (rd_pend),
        .wr_pend    (wr_pend),
        .tx_addr    (tx_addr),
        .tx_data    (tx_data)
    );

    phy_req_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_pend   (rd_pend),
        .wr_pend   (wr_pend),
        .tx_addr   (tx_addr),
        .tx_data   (tx_data),
        .req_ready (req_ready),
        .req_valid (req_valid),
        .req_out   (req_bus),
        .rd_done   (rd_done),
        .wr_done   (wr_done)
    );

    phy_rsp_regs u_rsp (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr_en (host_wr_en),
        .diag_wr_en (diag_wr_en),
        .host_wdata (host_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_addr   (rsp_addr),
        .rsp_data   (rsp_data),
        .irq_clr    (irq_clr),
        .rx_addr    (rx_addr),
        .rx_data    (rx_data),
        .rx_irq     (rx_irq)
    );

    always_comb begin
        req_is_write = req_bus.is_write;
        req_addr     = req_bus.addr;
        req_data     = req_bus.data;
        host_rdata   = '0;
        host_rdata[RD_CMD_BIT]                = rd_pend;
        host_rdata[WR_CMD_BIT]                = wr_pend;
        host_rdata[TX_ADDR_LSB +: PA_W]       = tx_addr;
        host_rdata[TX_DATA_LSB +: PD_W]       = tx_data;
        host_rdata[RX_ADDR_LSB +: PA_W]       = rx_addr;
        host_rdata[RX_DATA_LSB +: PD_W]       = rx_data;
    end

endmodule

// File: rtl/phy_reg_bridge_chk.sv
module phy_reg_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr_en,
    input logic [31:0] host_wdata,
    input logic [31:0] host_rdata,
    input logic        irq_clr,
    input logic        diag_wr_en,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_is_write,
    input logic [3:0]  req_addr,
    input logic [7:0]  req_data,
    input logic        rsp_valid,
    input logic [3:0]  rsp_addr,
    input logic [7:0]  rsp_data,
    input logic        rx_irq
);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[29:28] == 2'b00 && host_rdata[15:12] == 4'h0); // R2

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_is_write)
                                    && $stable(req_addr) && $stable(req_data)); // R5

    AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_is_write && !(host_wr_en && host_wdata[31])
        |=> !host_rdata[31]); // R5

    AST_WR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_is_write && !(host_wr_en && host_wdata[30])
        |=> !host_rdata[30]); // R5

    AST_RSP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> rx_irq && host_rdata[11:0] == {$past(rsp_addr), $past(rsp_data)}); // R7

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq && !irq_clr |=> rx_irq); // R8

    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr && !rsp_valid |=> !rx_irq); // R8

    AST_RX_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid && !(host_wr_en && diag_wr_en) |=> $stable(host_rdata[11:0])); // R9

endmodule

bind phy_reg_bridge phy_reg_bridge_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr_en   (host_wr_en),
    .host_wdata   (host_wdata),
    .host_rdata   (host_rdata),
    .irq_clr      (irq_clr),
    .diag_wr_en   (diag_wr_en),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_is_write (req_is_write),
    .req_addr     (req_addr),
    .req_data     (req_data),
    .rsp_valid    (rsp_valid),
    .rsp_addr     (rsp_addr),
    .rsp_data     (rsp_data),
    .rx_irq       (rx_irq)
);

// File: tb/phy_reg_bridge_tb.sv
module phy_reg_bridge_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        irq_clr = 1'b0;
    logic        diag_wr_en = 1'b0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic        req_is_write;
    logic [3:0]  req_addr;
    logic [7:0]  req_data;
    logic        rsp_valid = 1'b0;
    logic [3:0]  rsp_addr = '0;
    logic [7:0]  rsp_data = '0;
    logic        rx_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    phy_reg_bridge u_dut (
        .clk (clk), .rst_n (rst_n),
        .host_wr_en (host_wr_en), .host_wdata (host_wdata), .host_rdata (host_rdata),
        .irq_clr (irq_clr), .diag_wr_en (diag_wr_en),
        .req_valid (req_valid), .req_ready (req_ready), .req_is_write (req_is_write),
        .req_addr (req_addr), .req_data (req_data),
        .rsp_valid (rsp_valid), .rsp_addr (rsp_addr), .rsp_data (rsp_data),
        .rx_irq (rx_irq)
    );

    function automatic logic [31:0] pack_word(logic rd, logic wr, logic [3:0] ta,
                                              logic [7:0] td, logic [3:0] ra, logic [7:0] rd8);
        return {rd, wr, 2'b00, ta, td, 4'h0, ra, rd8};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one rising edge, then settle to the falling edge; inputs go back to idle
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        host_wr_en = 1'b0;
        irq_clr    = 1'b0;
        rsp_valid  = 1'b0;
    endtask

    task automatic hwrite(logic [31:0] w);
        host_wr_en = 1'b1;
        host_wdata = w;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [11:0] m_tx;
        logic [11:0] m_rx;
        logic        m_irq;

        @(negedge clk);
        chk("R1 rdata during reset", host_rdata, 32'h0);
        tick(); tick();
        rst_n = 1'b1;
        tick();
        chk("R1 rdata", host_rdata, 32'h0);
        chk("R1 irq", {31'h0, rx_irq}, 32'h0);
        chk("R1 req_valid", {31'h0, req_valid}, 32'h0);

        // R2 and R9: fields, reserved bits, rx ignored without diag
        hwrite(32'h3FFF_FFFF);
        tick();
        chk("R2 fields and reserved", host_rdata, pack_word(0, 0, 4'hF, 8'hFF, 4'h0, 8'h00));
        chk("R9 rx ignored without diag", {20'h0, host_rdata[11:0]}, 32'h0);

        // R3 read command with PHY stalling
        hwrite(32'h8A55_0000);
        tick();
        chk("R3 cmd bit set", {31'h0, host_rdata[31]}, 32'h1);
        chk("R3 not yet valid", {31'h0, req_valid}, 32'h0);
        tick();
        chk("R3 request", {19'h0, req_valid, req_is_write, req_addr, req_data}, {19'h0, 1'b1, 1'b0, 4'hA, 8'h55});
        // R10: writing zeros while pending does not cancel or alter payload
        hwrite(32'h0000_0000);
        tick();
        chk("R10 cmd still set", {31'h0, host_rdata[31]}, 32'h1);
        chk("R10 payload held", {27'h0, req_valid, req_addr}, {27'h0, 1'b1, 4'hA});
        tick();
        chk("R5 held while stalled", {19'h0, req_valid, req_is_write, req_addr, req_data}, {19'h0, 1'b1, 1'b0, 4'hA, 8'h55});
        chk("R5 cmd held", {31'h0, host_rdata[31]}, 32'h1);
        req_ready = 1'b1;
        tick();
        chk("R5 cleared after handshake", {30'h0, host_rdata[31], req_valid}, 32'h0);

        // R4 write command
        hwrite(32'h4C3C_0000);
        tick();
        tick();
        chk("R4 request", {19'h0, req_valid, req_is_write, req_addr, req_data}, {19'h0, 1'b1, 1'b1, 4'hC, 8'h3C});
        tick();
        chk("R4 cleared", {30'h0, host_rdata[30], req_valid}, 32'h0);

        // R6 both commands
        hwrite(32'hC512_0000);
        tick();
        chk("R6 both set", {30'h0, host_rdata[31:30]}, 32'h3);
        tick();
        chk("R6 read first", {19'h0, req_valid, req_is_write, req_addr, req_data}, {19'h0, 1'b1, 1'b0, 4'h5, 8'h12});
        tick();
        chk("R6 gap after read", {29'h0, host_rdata[31:30], req_valid}, {29'h0, 2'b01, 1'b0});
        tick();
        chk("R6 write second", {19'h0, req_valid, req_is_write, req_addr, req_data}, {19'h0, 1'b1, 1'b1, 4'h5, 8'h12});
        tick();
        chk("R6 all done", {29'h0, host_rdata[31:30], req_valid}, 32'h0);
        req_ready = 1'b0;

        // R7 response capture
        rsp_valid = 1'b1; rsp_addr = 4'h3; rsp_data = 8'h9A;
        tick();
        chk("R7 rx fields", {20'h0, host_rdata[11:0]}, 32'h39A);
        chk("R7 irq set", {31'h0, rx_irq}, 32'h1);

        // R8 sticky, clear, set wins
        tick();
        chk("R8 sticky", {31'h0, rx_irq}, 32'h1);
        irq_clr = 1'b1;
        tick();
        chk("R8 cleared", {31'h0, rx_irq}, 32'h0);
        irq_clr = 1'b1; rsp_valid = 1'b1; rsp_addr = 4'h7; rsp_data = 8'h01;
        tick();
        chk("R8 response beats clear", {31'h0, rx_irq}, 32'h1);
        irq_clr = 1'b1;
        tick();

        // R9 diagnostic writes
        diag_wr_en = 1'b1;
        hwrite(32'h0000_0B77);
        tick();
        chk("R9 diag write", {20'h0, host_rdata[11:0]}, 32'hB77);
        chk("R9 diag no irq", {31'h0, rx_irq}, 32'h0);
        hwrite(32'h0000_0C11);
        rsp_valid = 1'b1; rsp_addr = 4'h2; rsp_data = 8'hEE;
        tick();
        chk("R9 response beats diag", {20'h0, host_rdata[11:0]}, 32'h2EE);
        diag_wr_en = 1'b0;

        // Random phase on field and response logic (R2, R7, R8, R9)
        m_tx  = host_rdata[27:16];
        m_rx  = host_rdata[11:0];
        m_irq = rx_irq;
        void'($urandom(32'd1234));
        for (int i = 0; i < 400; i++) begin
            logic [31:0] w;
            w          = $urandom() & 32'h3FFF_FFFF;
            host_wr_en = ($urandom() % 4) == 0;
            host_wdata = w;
            diag_wr_en = ($urandom() % 2) == 0;
            rsp_valid  = ($urandom() % 4) == 0;
            rsp_addr   = 4'($urandom());
            rsp_data   = 8'($urandom());
            irq_clr    = ($urandom() % 4) == 0;
            if (host_wr_en) m_tx = w[27:16];
            if (rsp_valid) m_rx = {rsp_addr, rsp_data};
            else if (host_wr_en && diag_wr_en) m_rx = w[11:0];
            if (rsp_valid) m_irq = 1'b1;
            else if (irq_clr) m_irq = 1'b0;
            tick();
            chk("R9 random word", host_rdata, pack_word(0, 0, m_tx[11:8], m_tx[7:0], m_rx[11:8], m_rx[7:0]));
            chk("R8 random irq", {31'h0, rx_irq}, {31'h0, m_irq});
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule